// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache between a requester and a slower word memory. It holds 1024 one-word frames arranged as 256 sets of four ways. A 32-bit byte address is split into a 2-bit byte offset, an 8-bit set index and a 22-bit tag. One cycle after a request is accepted, the valid bits, tags and data of all four ways in the indexed set are available. The tags are compared in parallel. An AND-OR four-input selector passes on the data of the matching way. Data read alongside a failing compare is dropped.

On a miss the block picks a frame to replace. An invalid way of the set is used first, lowest way number first. Once all four ways are valid, a free-running linear feedback shift register supplies a pseudo-random way. The block then fetches the word through a request/acknowledge memory port, writes it into the chosen frame, and returns it to the requester flagged as refilled. There is no write path.

Top module: `sa4_read_cache`

## Requirements
- R1: The set index is address bits [9:2] and the tag is bits [31:10]. Bits [1:0] take no part in the lookup, so any byte of a cached word hits. Addresses with the same index and different tags occupy separate frames.
- R2: Reset clears every valid bit. A way counts as a hit only when its valid bit is set and its stored tag equals the request tag, so the first access to any word after reset misses.
- R3: A request is accepted on a rising edge where cpu_req is high and cpu_busy is low. On a hit, rsp_valid is high in the cycle that follows the second rising edge after acceptance, with rsp_refill low and rsp_data equal to the cached word.
- R4: On a miss, mem_req rises after the second edge following acceptance. It stays high, with mem_addr fixed at address bits [31:2], until the edge that samples mem_ack high.
- R5: The edge that samples mem_ack during a fill writes mem_data into the chosen frame, marks it valid, drops mem_req, and presents rsp_valid with rsp_refill high and rsp_data equal to the sampled mem_data. A later access to the same word hits.
- R6: While a set has an invalid way, a miss fills an invalid way and evicts nothing. Four distinct tags in one set therefore all stay resident.
- R7: A miss to a full set replaces exactly one way, chosen by the pseudo-random register. The new word is resident afterwards, and at least one of the previous four tags has been displaced.
- R8: cpu_busy is high from the acceptance edge until the response is presented. A request made while busy is ignored. mem_ack is ignored unless a fill is waiting.
- R9: At most one way of a set matches a lookup.
- R10: rsp_valid is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_busy | output | 1 | Lookup or fill in progress; requests are ignored |
| rsp_valid | output | 1 | Response word is valid this cycle |
| rsp_data | output | 32 | Response word |
| rsp_refill | output | 1 | Response came from memory after a miss |
| mem_req | output | 1 | Fill request to memory |
| mem_addr | output | 30 | Word address of the fill |
| mem_ack | input | 1 | Memory returns the fill word this cycle |
| mem_data | input | 32 | Fill word |

## Verification
Counting from the acceptance edge, a hit response is due one and a half cycles later, at the second falling edge. A miss raises mem_req at that same point. The refill response follows one cycle after the falling edge at which the bench drives mem_ack, so a fill that waits L cycles responds at falling edge 3+L. The access task counts falling edges from acceptance and compares the count at which rsp_valid is first seen with 2 or 3+L. It samples the response data only at that edge and checks at the following edge that rsp_valid has dropped. The stimulus table varies L from access to access, and a directed test holds a competing request high through a long fill.

// File: rtl/sa4_read_cache.sv
module sa4_read_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 2,
  parameter int WAYS   = 4,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic [ADDR_W-1:0]       cpu_addr,
  output logic                    cpu_busy,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_refill,
  output logic                    mem_req,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL} state_t;

  state_t              state;
  logic [BLK_W-1:0]    blk_q;
  logic [WAYS-1:0]     valid_q [SETS];
  logic [WAYS-1:0]     vld_set;
  logic [WAYS-1:0]     way_hit;
  logic [TAG_W-1:0]    way_tag [WAYS];
  logic [DATA_W-1:0]   way_dat [WAYS];
  logic [DATA_W-1:0]   hit_data;
  logic [WAY_W-1:0]    victim, victim_q;
  logic [LFSR_W-1:0]   lfsr;

  wire [IDX_W-1:0] idx_in  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  wire [IDX_W-1:0] idx_q   = blk_q[IDX_W-1:0];
  wire [TAG_W-1:0] tag_q   = blk_q[BLK_W-1:IDX_W];
  wire             accept  = (state == S_IDLE) && cpu_req;
  wire             fill_we = (state == S_FILL) && mem_ack;
  wire             hit_any = |way_hit;
  wire             unused_offset = ^cpu_addr[OFF_W-1:0];

  assign vld_set  = valid_q[idx_q];
  assign cpu_busy = (state != S_IDLE);
  assign mem_req  = (state == S_FILL);
  assign mem_addr = blk_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [DATA_W-1:0] dat_mem [SETS];
    logic [TAG_W-1:0]  tag_rd;
    logic [DATA_W-1:0] dat_rd;

    always_ff @(posedge clk) begin
      if (fill_we && victim_q == WAY_W'(w)) begin
        tag_mem[idx_q] <= tag_q;
        dat_mem[idx_q] <= mem_data;
      end
      if (accept) begin
        tag_rd <= tag_mem[idx_in];
        dat_rd <= dat_mem[idx_in];
      end
    end

    assign way_tag[w] = tag_rd;
    assign way_dat[w] = dat_rd;
    assign way_hit[w] = vld_set[w] && (way_tag[w] == tag_q);
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      hit_data = hit_data | (way_dat[w] & {DATA_W{way_hit[w]}});
  end

  always_comb begin
    victim = lfsr[WAY_W-1:0];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_set[w]) victim = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & LFSR_TAPS)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      blk_q      <= '0;
      victim_q   <= '0;
      rsp_valid  <= 1'b0;
      rsp_refill <= 1'b0;
      rsp_data   <= '0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (cpu_req) begin
          blk_q <= cpu_addr[ADDR_W-1:OFF_W];
          state <= S_LOOK;
        end
        S_LOOK: if (hit_any) begin
          rsp_valid  <= 1'b1;
          rsp_refill <= 1'b0;
          rsp_data   <= hit_data;
          state      <= S_IDLE;
        end else begin
          victim_q <= victim;
          state    <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          valid_q[idx_q][victim_q] <= 1'b1;
          rsp_valid  <= 1'b1;
          rsp_refill <= 1'b1;
          rsp_data   <= mem_data;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa4_read_cache_chk.sv
module sa4_read_cache_chk #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 30,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_busy,
  input logic              rsp_valid,
  input logic              rsp_refill,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [BLK_W-1:0]  mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [WAYS-1:0]   way_hit
);
  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  p_lookup_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy) |=> ##1 ((rsp_valid && !rsp_refill) || mem_req));

  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_refill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (rsp_valid && rsp_refill && !mem_req && rsp_data == $past(mem_data)));

  p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy) |=> cpu_busy);

  p_no_fill_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_busy |-> !mem_req);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sa4_read_cache sa4_read_cache_chk #(
  .DATA_W(DATA_W), .BLK_W(ADDR_W - OFF_W), .WAYS(WAYS)
) u_chk (.*);

// File: tb/test_sa4_read_cache.sv
module test_sa4_read_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_busy, rsp_valid, rsp_refill, mem_req;
  logic [31:0] rsp_data;
  logic [29:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sa4_read_cache i_sa4_read_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_busy(cpu_busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_refill(rsp_refill), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_data(mem_data)
  );

  function automatic logic [31:0] pat(input logic [29:0] w);
    return {w[13:0], w[29:12]} ^ 32'h6D2B_79F5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit 32: refill expected; bits 31:0: byte address
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'h0000_1000}, {1'b0, 32'h0000_1000}, {1'b0, 32'h0000_1002},
    {1'b1, 32'h0000_1400}, {1'b0, 32'h0000_1000}, {1'b1, 32'h0000_1004},
    {1'b1, 32'h0000_1800}, {1'b1, 32'h0000_1C00}, {1'b0, 32'h0000_1000},
    {1'b0, 32'h0000_1400}, {1'b0, 32'h0000_1800}, {1'b0, 32'h0000_1C00},
    {1'b1, 32'hFFFF_FFFC}, {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h0000_03FC},
    {1'b0, 32'hFFFF_FFFC}
  };

  task automatic access(input logic [31:0] a, input int lat, input bit hold,
                        input logic [31:0] side, output logic [31:0] d,
                        output logic rf, output int n);
    int  waitc;
    bit  done;
    @(negedge clk);
    cpu_req  = 1'b1;
    cpu_addr = a;
    @(posedge clk);
    @(negedge clk);
    if (hold) cpu_addr = side;
    else      cpu_req  = 1'b0;
    n = 1; waitc = 0; done = 0; d = '0; rf = 1'b0;
    chk(cpu_busy == 1'b1, "R8", "busy after accept", cpu_busy, 1);
    while (!done && n < 100) begin
      if (rsp_valid) begin
        d = rsp_data; rf = rsp_refill; done = 1;
        cpu_req = 1'b0;
      end else begin
        if (mem_req) begin
          if (waitc == 0)
            chk(mem_addr == a[31:2], "R4", "fill word address", mem_addr, a[31:2]);
          if (waitc == lat) begin
            mem_ack  = 1'b1;
            mem_data = pat(mem_addr);
          end
          waitc++;
        end
        @(negedge clk);
        mem_ack = 1'b0;
        n++;
      end
    end
    cpu_req = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "response is one cycle", rsp_valid, 0);
  endtask

  task automatic expect_read(input logic [31:0] a, input bit exp_rf, input int lat,
                             input string req);
    logic [31:0] d;
    logic        rf;
    int          n;
    access(a, lat, 1'b0, 32'h0, d, rf, n);
    chk(rf == exp_rf, req, "refill flag", rf, exp_rf);
    chk(d == pat(a[31:2]), req, "data", d, pat(a[31:2]));
    chk(n == (exp_rf ? 3 + lat : 2), exp_rf ? "R5" : "R3", "response cycle", n,
        exp_rf ? 3 + lat : 2);
  endtask

  function automatic logic [31:0] set5(input int t);
    return (32'(t) << 10) | 32'h14;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        rf;
    int          n;
    int          first_miss;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2, R8: reset state
    chk(cpu_busy == 0 && rsp_valid == 0 && mem_req == 0, "R2", "idle after reset",
        {cpu_busy, rsp_valid, mem_req}, 0);

    // table walk: R1 index/tag/offset, R2 cold misses, R9 single-way selection
    for (int i = 0; i < NV; i++)
      expect_read(VEC[i][31:0], VEC[i][32], i % 3, VEC[i][32] ? "R2" : "R9");

    // R8: request held during a long fill is ignored
    access(32'h0000_2008, 4, 1'b1, 32'h0000_3008, d, rf, n);
    chk(n == 7, "R4", "long fill response cycle", n, 7);
    chk(d == pat(30'h802), "R8", "data of first request", d, pat(30'h802));
    expect_read(32'h0000_3008, 1'b1, 0, "R8");

    // R8: stray mem_ack while idle is ignored
    @(negedge clk);
    mem_ack = 1'b1; mem_data = 32'hDEAD_BEEF;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(rsp_valid == 0 && cpu_busy == 0, "R8", "stray ack ignored",
        {rsp_valid, cpu_busy}, 0);
    expect_read(32'h0000_2008, 1'b0, 0, "R8");

    // R6: four tags in one set stay resident
    for (int t = 0; t < 4; t++) expect_read(set5(t + 'h100), 1'b1, 1, "R6");
    for (int t = 0; t < 4; t++) expect_read(set5(t + 'h100), 1'b0, 0, "R6");

    // R7: fifth tag evicts one way
    expect_read(set5('h104), 1'b1, 0, "R7");
    expect_read(set5('h104), 1'b0, 0, "R7");
    first_miss = -1;
    for (int t = 0; t < 4; t++) begin
      if (first_miss < 0) begin
        access(set5(t + 'h100), 0, 1'b0, 32'h0, d, rf, n);
        chk(d == pat(set5(t + 'h100) >> 2), "R7", "data after eviction", d,
            pat(set5(t + 'h100) >> 2));
        if (rf) first_miss = t;
      end
    end
    chk(first_miss >= 0, "R7", "one old tag displaced", first_miss, 0);

    // R1: byte offset ignored on a set-5 entry
    expect_read(set5('h104) | 32'h3, 1'b0, 0, "R1");

    // R2: reset invalidates contents
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    expect_read(32'h0000_1000, 1'b1, 2, "R2");
    expect_read(32'h0000_1000, 1'b0, 0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule